// File: doc/BRIEF.md
# Gated ring phase readout converter

This block turns the frozen state of a gated ring oscillator into a binary accumulation count. The ring is made of an odd number of inverter stages, five by default. Each stage output is latched and fed in as one bit of `ring_i`. While `gate_i` is high, the block decodes the latched pattern into a fine phase code and follows it clock by clock. Each time the phase falls back through zero, it advances a coarse wrap counter. When the gate drops, the held phase and the count are kept. The next gated interval then carries on from that point, so the total builds up across many operations.

A read strobe copies the coarse count and the fine phase into output registers at the same clock edge. It also gives the combined value `coarse * 10 + fine`, with ten ring states per cycle by default, and raises a valid pulse. A pattern that is not a legal ring state raises a sticky error flag. A counter that has reached its full-scale value raises a sticky saturation flag. Together these tell the reader whether the accumulated value can still be trusted.

Top module: `ring_phase_readout`

## Requirements
- R1: The legal patterns are decoded as follows. XOR `ring_i` with the alternating mask 5'b01010 to get a thermometer code. Phase k, for k from 0 to 5, has exactly the lowest k bits set. Phase k, for k from 6 to 9, has exactly the highest 10-k bits set. No other pattern is legal.
- R2: While `gate_i` is high and the pattern is legal, the held phase takes the decoded phase at each clock. While `gate_i` is low, `ring_i` is ignored and the phase, the count and the flags do not change.
- R3: A gated, legal decoded phase that is lower than the held phase counts as one wrap and adds one to the coarse count. An equal or higher phase adds nothing.
- R4: A gated, illegal pattern sets `err_o`. The flag stays set until reset. The held phase and the count are left unchanged.
- R5: The coarse count stops at 2^CNT_W-1, which is 255 by default. The wrap that reaches this value sets `sat_o`. The flag stays set until reset, and later wraps do not change the count.
- R6: At a clock edge where `rd_i` is high, `coarse_o` and `fine_o` take the count and the held phase as they stood just before that edge. Between strobes they hold their values.
- R7: `valid_o` is high for exactly the one cycle that follows each cycle in which `rd_i` is high.
- R8: `value_o` equals `coarse_o * 10 + fine_o`.
- R9: An active-low asynchronous reset `rst_ni` clears the phase, the count, both flags, the read fields and `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_i | input | 5 | Latched inverter outputs of the ring |
| gate_i | input | 1 | High while the ring is gated on |
| rd_i | input | 1 | Read strobe |
| coarse_o | output | 8 | Coarse wrap count from the last read |
| fine_o | output | 4 | Fine phase from the last read |
| value_o | output | 12 | Combined value, coarse * 10 + fine |
| valid_o | output | 1 | One-cycle pulse after a read strobe |
| sat_o | output | 1 | Sticky flag: the counter has reached full scale |
| err_o | output | 1 | Sticky flag: an illegal ring pattern was seen while gated |

## Verification
The hardest condition to reach is saturation. It needs 255 separate wraps, and each wrap needs a legal phase sequence that drops back through zero while the gate is held. The stimulus bounces the ring between phase 5 and phase 0, one clock each, well past full scale. It then checks that later wraps leave the count where it stopped. Multi-step phase jumps, gated-off pattern changes and illegal patterns are mixed in, so that wrap detection is tested against phase steps that skip states.

// File: rtl/ring_phase_pkg.sv
package ring_phase_pkg;
  localparam int unsigned DEF_STAGES = 5;
  localparam int unsigned DEF_CNT_W  = 8;

  // alternating mask that turns an inverter ring state into a thermometer code
  function automatic logic [31:0] alt_mask(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) m[i] = (i % 2 == 1) && (i < n);
    return m;
  endfunction

  // thermometer form of phase k for a ring of given stage count
  function automatic logic [31:0] therm_pat(input int unsigned stages, input int unsigned k);
    logic [31:0] p;
    p = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < stages) p[i] = (k <= stages) ? (i < k) : (i >= k - stages);
    end
    return p;
  endfunction
endpackage

// File: rtl/ring_state_decoder.sv
module ring_state_decoder
  import ring_phase_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES,
  parameter int unsigned PH_W   = $clog2(2 * STAGES)
) (
  input  logic [STAGES-1:0] ring_i,
  output logic              legal_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam int unsigned STATES = 2 * STAGES;
  localparam logic [31:0] MASK32 = alt_mask(STAGES);
  localparam logic [STAGES-1:0] MASK = MASK32[STAGES-1:0];

  logic [STATES-1:0] hit;

  for (genvar k = 0; k < STATES; k++) begin : g_state
    localparam logic [31:0] PAT32 = therm_pat(STAGES, k);
    assign hit[k] = (ring_i == (PAT32[STAGES-1:0] ^ MASK));
  end

  always_comb begin
    legal_o = |hit;
    phase_o = '0;
    for (int k = 0; k < STATES; k++) begin
      if (hit[k]) phase_o = PH_W'(k);
    end
  end
endmodule

// File: rtl/ring_wrap_tracker.sv
module ring_wrap_tracker #(
  parameter int unsigned PH_W  = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             legal_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [CNT_W-1:0] count_o,
  output logic             sat_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sat_q, err_q;
  logic             upd, wrap, bump;

  always_comb begin
    upd  = gate_i & legal_i;
    wrap = upd & (phase_i < phase_q);
    bump = wrap & (cnt_q != CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cnt_q   <= '0;
      sat_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (upd) phase_q <= phase_i;
      if (bump) cnt_q <= cnt_q + 1'b1;
      if (bump && (cnt_q == CNT_MAX - 1'b1)) sat_q <= 1'b1;
      if (gate_i && !legal_i) err_q <= 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign count_o = cnt_q;
  assign sat_o   = sat_q;
  assign err_o   = err_q;
endmodule

// File: rtl/ring_readout_snap.sv
module ring_readout_snap #(
  parameter int unsigned PH_W   = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned STATES = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_i,
  input  logic [CNT_W-1:0]      count_i,
  input  logic [PH_W-1:0]       phase_i,
  output logic [CNT_W-1:0]      coarse_o,
  output logic [PH_W-1:0]       fine_o,
  output logic [CNT_W+PH_W-1:0] value_o,
  output logic                  valid_o
);
  localparam int unsigned SUM_W = CNT_W + PH_W;

  logic [CNT_W-1:0] coarse_q;
  logic [PH_W-1:0]  fine_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      fine_q   <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) begin
        coarse_q <= count_i;
        fine_q   <= phase_i;
      end
    end
  end

  assign coarse_o = coarse_q;
  assign fine_o   = fine_q;
  assign valid_o  = vld_q;
  assign value_o  = SUM_W'(coarse_q) * SUM_W'(STATES) + SUM_W'(fine_q);
endmodule

// File: rtl/ring_phase_readout.sv
module ring_phase_readout
  import ring_phase_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned PH_W  = $clog2(2 * STAGES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [STAGES-1:0]     ring_i,
  input  logic                  gate_i,
  input  logic                  rd_i,
  output logic [CNT_W-1:0]      coarse_o,
  output logic [PH_W-1:0]       fine_o,
  output logic [CNT_W+PH_W-1:0] value_o,
  output logic                  valid_o,
  output logic                  sat_o,
  output logic                  err_o
);
  localparam int unsigned STATES = 2 * STAGES;

  logic             legal_w;
  logic [PH_W-1:0]  dec_phase_w;
  logic [PH_W-1:0]  phase_w;
  logic [CNT_W-1:0] cnt_w;

  ring_state_decoder #(.STAGES(STAGES), .PH_W(PH_W)) u_dec (
    .ring_i (ring_i),
    .legal_o(legal_w),
    .phase_o(dec_phase_w)
  );

  ring_wrap_tracker #(.PH_W(PH_W), .CNT_W(CNT_W)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .legal_i(legal_w),
    .phase_i(dec_phase_w),
    .phase_o(phase_w),
    .count_o(cnt_w),
    .sat_o  (sat_o),
    .err_o  (err_o)
  );

  ring_readout_snap #(.PH_W(PH_W), .CNT_W(CNT_W), .STATES(STATES)) u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .count_i (cnt_w),
    .phase_i (phase_w),
    .coarse_o(coarse_o),
    .fine_o  (fine_o),
    .value_o (value_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/ring_phase_readout_chk.sv
module ring_phase_readout_chk #(
  parameter int unsigned STAGES = 5,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned PH_W  = $clog2(2 * STAGES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] coarse_o,
  input logic [PH_W-1:0]  fine_o,
  input logic             valid_o,
  input logic             sat_o,
  input logic             err_o,
  input logic [PH_W-1:0]  held_phase,
  input logic [CNT_W-1:0] held_cnt
);
  localparam int unsigned STATES = 2 * STAGES;

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_i |=> valid_o);
  // R7
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_i |=> !valid_o);
  // R6
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ($stable(coarse_o) && $stable(fine_o)));
  // R6
  snap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (coarse_o == $past(held_cnt) && fine_o == $past(held_phase)));
  // R5
  sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sat_o |=> sat_o);
  // R5
  sat_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sat_o |=> $stable(held_cnt));
  // R4
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> err_o);
  // R2
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> ($stable(held_phase) && $stable(held_cnt)));
  // R1
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) held_phase < PH_W'(STATES));
endmodule

bind ring_phase_readout ring_phase_readout_chk #(.STAGES(STAGES), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_i    (gate_i),
  .rd_i      (rd_i),
  .coarse_o  (coarse_o),
  .fine_o    (fine_o),
  .valid_o   (valid_o),
  .sat_o     (sat_o),
  .err_o     (err_o),
  .held_phase(phase_w),
  .held_cnt  (cnt_w)
);

// File: tb/ring_phase_readout_test.sv
`timescale 1ns/1ps
module ring_phase_readout_test;
  localparam int MAXC = 255;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  ring_i = 5'b01010;
  logic        gate_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  coarse_o;
  logic [3:0]  fine_o;
  logic [11:0] value_o;
  logic        valid_o, sat_o, err_o;

  int vectors = 0, fails = 0;
  bit done = 0;
  int m_phase, m_cnt, m_sat, m_err, s_coarse, s_fine, s_valid;

  ring_phase_readout uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ring_i(ring_i), .gate_i(gate_i), .rd_i(rd_i),
    .coarse_o(coarse_o), .fine_o(fine_o), .value_o(value_o), .valid_o(valid_o),
    .sat_o(sat_o), .err_o(err_o)
  );

  always #4 clk_i = ~clk_i;

  // legal ring pattern for phase k (R1 encoding)
  function automatic logic [4:0] pat(input int k);
    logic [4:0] t;
    for (int i = 0; i < 5; i++) t[i] = (k <= 5) ? (i < k) : (i >= k - 5);
    return t ^ 5'b01010;
  endfunction

  function automatic int decode(input logic [4:0] p);
    for (int k = 0; k < 10; k++) if (pat(k) == p) return k;
    return -1;
  endfunction

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, fld, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "coarse", int'(coarse_o), s_coarse);
    chk(tag, "fine", int'(fine_o), s_fine);
    chk(tag, "value R8", int'(value_o), s_coarse * 10 + s_fine);
    chk(tag, "valid R7", int'(valid_o), s_valid);
    chk(tag, "sat R5", int'(sat_o), m_sat);
    chk(tag, "err R4", int'(err_o), m_err);
  endtask

  function automatic void clear_model();
    m_phase = 0; m_cnt = 0; m_sat = 0; m_err = 0;
    s_coarse = 0; s_fine = 0; s_valid = 0;
  endfunction

  // called at a negedge: drive, let one edge pass, update model, compare at next negedge
  task automatic step(input logic g, input logic [4:0] p, input logic rd, input string tag);
    int dk;
    gate_i = g; ring_i = p; rd_i = rd;
    @(posedge clk_i);
    s_valid = rd ? 1 : 0;
    if (rd) begin s_coarse = m_cnt; s_fine = m_phase; end
    if (g) begin
      dk = decode(p);
      if (dk < 0) m_err = 1;
      else begin
        if (dk < m_phase && m_cnt < MAXC) begin
          m_cnt++;
          if (m_cnt == MAXC) m_sat = 1;
        end
        m_phase = dk;
      end
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic read(input string tag);
    step(1'b0, 5'b00000, 1'b1, tag);
    step(1'b0, 5'b00000, 1'b0, tag);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk_i);
    compare("R9 reset");
    rst_ni = 1'b1;
    // R1: walk all ten legal states, reading each one
    for (int k = 0; k < 10; k++) begin
      step(1'b1, pat(k), 1'b0, "R1");
      read("R1");
    end
    // R3: wrap from 9 to 0, then skipped-state jumps
    step(1'b1, pat(0), 1'b0, "R3"); read("R3");
    step(1'b1, pat(3), 1'b0, "R3");
    step(1'b1, pat(7), 1'b0, "R3");
    step(1'b1, pat(2), 1'b0, "R3");
    step(1'b1, pat(2), 1'b0, "R3");
    step(1'b1, pat(8), 1'b1, "R3 R6");
    read("R3");
    // R2: gate low, ring moves, nothing changes
    step(1'b0, pat(1), 1'b0, "R2");
    step(1'b0, 5'b11111, 1'b0, "R2");
    step(1'b0, pat(4), 1'b0, "R2");
    read("R2");
    // resume from held phase 8: 9 then 1 wraps once
    step(1'b1, pat(9), 1'b0, "R2");
    step(1'b1, pat(1), 1'b0, "R2");
    read("R2");
    // R6: fields hold between strobes
    for (int i = 0; i < 3; i++) step(1'b1, pat(6 + i), 1'b0, "R6");
    step(1'b1, pat(0), 1'b1, "R6");
    step(1'b1, pat(4), 1'b1, "R6 R7");
    step(1'b0, pat(4), 1'b0, "R7");
    // R4: illegal patterns hold phase and count
    step(1'b1, 5'b11111, 1'b0, "R4");
    step(1'b1, 5'b00000, 1'b0, "R4");
    read("R4");
    step(1'b1, pat(2), 1'b0, "R4");
    read("R4");
    // R9: asynchronous reset mid-run
    @(negedge clk_i);
    vectors++;
    rst_ni = 1'b0; gate_i = 1'b0; rd_i = 1'b0;
    clear_model();
    #1 compare("R9 async");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R5: drive the counter to full scale and beyond
    for (int i = 0; i < 270; i++) begin
      step(1'b1, pat(5), 1'b0, "R5");
      step(1'b1, pat(0), (i % 64) == 0, "R5");
    end
    read("R5");
    step(1'b1, pat(9), 1'b0, "R5");
    step(1'b1, pat(3), 1'b0, "R5");
    read("R5");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule